// File: doc/BRIEF.md
# Analog Self-Test Stimulus Generator

This block produces the digital words that feed a DAC while the analog path behind it is under self-test. One shared core register works as an up counter, a down counter, a reversing (triangle) counter or a linear feedback shift register. A magnitude register, a one-hot sweep shift register, a step toggle flop and a staircase holding register shape the core value into sixteen selectable waveforms. These cover ramps, triangle, pseudo-random noise, DC level, step, impulse, frequency sweeps of fixed and varying amplitude, and a staircase, plus bit-reversed versions of most of them.

Software writes a 4-bit waveform code and a magnitude over a two-register write port. While the test enable is high, the DAC receives the selected pattern. While it is low, the DAC receives the system data combinationally and the waveform state stays parked at its starting point. Every test run therefore begins from a known phase.

Top module: `tpg_top`

## Requirements
- R1: With `bist_en_i` low, `dac_o` equals `sys_data_i` in the same cycle and the waveform state is held at its start value; the first pattern word after `bist_en_i` rises is the start word (t = 0), and every rising clock edge with the enable high advances t by one.
- R2: A write with `wr_addr_i`=0 loads the waveform code from `wr_data_i[3:0]` and restarts the waveform at t = 0 on the following cycle; a write with `wr_addr_i`=1 loads the magnitude M from `wr_data_i`. Reset leaves code 0 and M = 0.
- R3: Code 0 outputs the up ramp t mod 2^DW. Code 1 outputs the down ramp (-t) mod 2^DW.
- R4: Code 2 outputs a triangle 0,1,…,2^DW-1,2^DW-2,…,1,0,… with period 2·(2^DW-1); the direction flips exactly when the count reaches all-ones or all-zeros.
- R5: Code 3 outputs a maximal-length LFSR sequence seeded with 1 at t = 0. It shifts left, and the new bit 0 is the XOR of the tapped bits (for DW = 4, bits 3 and 2). It never outputs zero and has period 2^DW-1.
- R6: Code 4 outputs M as a DC level; a magnitude write takes effect on the next cycle and does not restart the waveform.
- R7: Code 5 is a step: 0 for t mod 2^(DW+1) < 2^DW, else M. Code 6 is an impulse: M when t mod 2^DW = 0, else 0.
- R8: Codes 7 and 8 are frequency sweeps. The sweep stage is k = (t div 2^DW) mod SW, and the output is active when bit k of (t mod 2^DW) is 1. Code 7 outputs M when active; code 8 outputs (2^DW-1)>>k when active. Both output 0 otherwise.
- R9: Code 9 is a staircase from the holding register: (t mod 2^DW) with its HW low bits cleared.
- R10: Codes 10, 11, 12, 13, 14 and 15 are the waveforms of codes 0, 1, 2, 3, 7 and 8 with the output word bit-reversed (bit i moves to bit DW-1-i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bist_en_i | input | 1 | Selects the test pattern onto the DAC and lets the waveform run |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: waveform code, 1: magnitude |
| wr_data_i | input | DW | Write data |
| sys_data_i | input | DW | Normal-mode DAC data |
| dac_o | output | DW | Word to the DAC |

## Verification
The bench runs every one of the sixteen codes for more than two full core periods in a 4-bit configuration. It compares each cycle with values it computes from t, so a ramp that starts at 1, a triangle that repeats its end values or turns one count late, or a sweep that advances on the wrong edge each shows up as a one-word mismatch. The LFSR is checked against an independent shift sequence, which catches a wrong tap, a zero seed or a lock-up. A bit-reversal that is skipped or applied to the wrong codes shows up as mirrored words. The pass-through path is swept over all data values, and a magnitude write during an impulse run must change the amplitude without moving the impulse. A code write during a run must restart the waveform, and a design that forgot this would continue from its old phase.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_UP    = 4'd0,
    M_DOWN  = 4'd1,
    M_TRI   = 4'd2,
    M_LFSR  = 4'd3,
    M_DC    = 4'd4,
    M_STEP  = 4'd5,
    M_IMP   = 4'd6,
    M_SWC   = 4'd7,
    M_SWV   = 4'd8,
    M_STAIR = 4'd9,
    M_UP_R  = 4'd10,
    M_DN_R  = 4'd11,
    M_TRI_R = 4'd12,
    M_LFS_R = 4'd13,
    M_SWC_R = 4'd14,
    M_SWV_R = 4'd15
  } mode_e;

  typedef enum logic [1:0] {OP_UP, OP_DOWN, OP_TRI, OP_LFSR} core_op_e;

  typedef enum logic [2:0] {
    SRC_CORE, SRC_MAG, SRC_STEP, SRC_IMP, SRC_SWC, SRC_SWV, SRC_HOLD
  } src_e;

  function automatic core_op_e core_op(mode_e m);
    case (m)
      M_DOWN, M_DN_R:  return OP_DOWN;
      M_TRI, M_TRI_R:  return OP_TRI;
      M_LFSR, M_LFS_R: return OP_LFSR;
      default:         return OP_UP;
    endcase
  endfunction

  function automatic src_e src_sel(mode_e m);
    case (m)
      M_DC:           return SRC_MAG;
      M_STEP:         return SRC_STEP;
      M_IMP:          return SRC_IMP;
      M_SWC, M_SWC_R: return SRC_SWC;
      M_SWV, M_SWV_R: return SRC_SWV;
      M_STAIR:        return SRC_HOLD;
      default:        return SRC_CORE;
    endcase
  endfunction

  function automatic logic is_rev(mode_e m);
    return m >= M_UP_R;
  endfunction

  // maximal-length feedback masks, bit n-1 set for tap n
  function automatic logic [23:0] lfsr_taps(int w);
    case (w)
      4:       return 24'h00000C;
      5:       return 24'h000014;
      6:       return 24'h000030;
      7:       return 24'h000060;
      8:       return 24'h0000B8;
      9:       return 24'h000110;
      10:      return 24'h000240;
      11:      return 24'h000500;
      12:      return 24'h000829;
      13:      return 24'h00100D;
      14:      return 24'h002015;
      15:      return 24'h006000;
      16:      return 24'h00D008;
      17:      return 24'h012000;
      18:      return 24'h020400;
      19:      return 24'h040023;
      20:      return 24'h090000;
      21:      return 24'h140000;
      22:      return 24'h300000;
      23:      return 24'h420000;
      default: return 24'hE10000;
    endcase
  endfunction

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bist_en_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output mode_e         mode_o,
  output mode_e         mode_nxt_o,
  output logic [DW-1:0] mag_o,
  output logic          init_o
);

  mode_e         mode_q;
  logic [DW-1:0] mag_q;
  logic          mode_wr;
  logic          mag_wr;

  assign mode_wr    = wr_en_i && !wr_addr_i;
  assign mag_wr     = wr_en_i && wr_addr_i;
  assign mode_nxt_o = mode_wr ? mode_e'(wr_data_i[MODE_W-1:0]) : mode_q;
  // waveform parks while disabled and restarts on a code write
  assign init_o     = !bist_en_i || mode_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_UP;
      mag_q  <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_e'(wr_data_i[MODE_W-1:0]);
      if (mag_wr)  mag_q  <= wr_data_i;
    end
  end

  assign mode_o = mode_q;
  assign mag_o  = mag_q;

  p_code_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (mode_o == mode_e'($past(wr_data_i[MODE_W-1:0]))));

  p_mag_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_wr |=> (mag_o == $past(wr_data_i)));

endmodule

// File: rtl/tpg_core.sv
module tpg_core
  import tpg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  core_op_e      op_i,
  input  core_op_e      seed_op_i,
  output logic [DW-1:0] core_o
);

  localparam logic [23:0]   TAP_ALL = lfsr_taps(DW);
  localparam logic [DW-1:0] TAPS    = TAP_ALL[DW-1:0];
  localparam logic [DW-1:0] TOP_V   = '1;
  localparam logic [DW-1:0] ONE_V   = DW'(1);

  logic [DW-1:0] core_q;
  logic [DW-1:0] tri_nxt;
  logic          dir_up_q;
  logic          fb;

  assign fb      = ^(core_q & TAPS);
  assign tri_nxt = dir_up_q ? core_q + ONE_V : core_q - ONE_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q   <= '0;
      dir_up_q <= 1'b1;
    end else if (init_i) begin
      core_q   <= (seed_op_i == OP_LFSR) ? ONE_V : '0;
      dir_up_q <= 1'b1;
    end else begin
      case (op_i)
        OP_UP:   core_q <= core_q + ONE_V;
        OP_DOWN: core_q <= core_q - ONE_V;
        OP_LFSR: core_q <= {core_q[DW-2:0], fb};
        default: begin
          core_q <= tri_nxt;
          // toggle flop turns at either terminal count
          if (dir_up_q && tri_nxt == TOP_V)      dir_up_q <= 1'b0;
          else if (!dir_up_q && tri_nxt == '0)   dir_up_q <= 1'b1;
        end
      endcase
    end
  end

  assign core_o = core_q;

  p_tri_top_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TRI && core_q == TOP_V) |-> !dir_up_q);

  p_tri_floor_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_TRI && core_q == '0) |-> dir_up_q);

  p_lfsr_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LFSR) |-> (core_q != '0));

endmodule

// File: rtl/tpg_aux.sv
module tpg_aux #(
  parameter int DW = 8,
  parameter int SW = 4,
  parameter int HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [DW-1:0] core_i,
  output logic [SW-1:0] psr_o,
  output logic          step_o,
  output logic [DW-1:0] hold_o
);

  localparam logic [DW-1:0] TOP_V = '1;
  localparam logic [HW-1:0] SUB_T = '1;
  localparam logic [DW-1:0] ONE_V = DW'(1);

  logic [SW-1:0] psr_q;
  logic          step_q;
  logic [DW-1:0] hold_q;
  logic          wrap;

  assign wrap = !init_i && core_i == TOP_V;

  generate
    if (SW == 1) begin : g_psr1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) psr_q <= 1'b1;
        else         psr_q <= 1'b1;
      end
    end else begin : g_psrn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     psr_q <= SW'(1);
        else if (init_i) psr_q <= SW'(1);
        else if (wrap)   psr_q <= {psr_q[SW-2:0], psr_q[SW-1]};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      hold_q <= '0;
    end else if (init_i) begin
      step_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (wrap) step_q <= !step_q;
      if (core_i[HW-1:0] == SUB_T) hold_q <= core_i + ONE_V;
    end
  end

  assign psr_o  = psr_q;
  assign step_o = step_q;
  assign hold_o = hold_q;

  p_step_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && core_i == TOP_V) |=> (step_o != $past(step_o)));

  p_sweep_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(psr_o) == 1);

  p_stair_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o[HW-1:0] == '0);

endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 4,
  parameter int HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bist_en_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] sys_data_i,
  output logic [DW-1:0] dac_o
);

  localparam logic [DW-1:0] ALL1 = '1;

  mode_e         mode, mode_nxt;
  logic [DW-1:0] mag;
  logic          init;
  logic [DW-1:0] core;
  logic [SW-1:0] psr;
  logic          step;
  logic [DW-1:0] hold;
  logic [DW-1:0] shaped;
  logic [DW-1:0] flipped;
  logic [DW-1:0] pattern;
  logic          sw_bit;
  int            k;

  tpg_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .bist_en_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .mode_nxt_o(mode_nxt), .mag_o(mag), .init_o(init)
  );

  tpg_core #(.DW(DW)) u_core (
    .clk_i, .rst_ni, .init_i(init),
    .op_i(core_op(mode)), .seed_op_i(core_op(mode_nxt)),
    .core_o(core)
  );

  tpg_aux #(.DW(DW), .SW(SW), .HW(HW)) u_aux (
    .clk_i, .rst_ni, .init_i(init), .core_i(core),
    .psr_o(psr), .step_o(step), .hold_o(hold)
  );

  always_comb begin
    k = 0;
    for (int i = 0; i < SW; i++) if (psr[i]) k = i;
  end

  assign sw_bit = core[k];

  always_comb begin
    case (src_sel(mode))
      SRC_MAG:  shaped = mag;
      SRC_STEP: shaped = step ? mag : '0;
      SRC_IMP:  shaped = (core == '0) ? mag : '0;
      SRC_SWC:  shaped = sw_bit ? mag : '0;
      SRC_SWV:  shaped = sw_bit ? (ALL1 >> k) : '0;
      SRC_HOLD: shaped = hold;
      default:  shaped = core;
    endcase
  end

  generate
    for (genvar b = 0; b < DW; b++) begin : g_rev
      assign flipped[b] = shaped[DW-1-b];
    end
  endgenerate

  assign pattern = is_rev(mode) ? flipped : shaped;
  assign dac_o   = bist_en_i ? pattern : sys_data_i;

endmodule

// File: tb/tpg_top_bench.sv
`timescale 1ns/1ps
module tpg_top_bench;

  localparam int DW = 4;
  localparam int SW = 2;
  localparam int HW = 2;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bist_en = 0;
  logic          wr_en = 0;
  logic          wr_addr = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] sys_data = '0;
  logic [DW-1:0] dac;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tpg_top #(.DW(DW), .SW(SW), .HW(HW)) u_tpg_top (
    .clk_i(clk), .rst_ni(rst_n), .bist_en_i(bist_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sys_data_i(sys_data),
    .dac_o(dac)
  );

  task automatic chk(input string r, input logic [DW-1:0] a, input logic [DW-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic start(input int m);
    bist_en = 0;
    wr(0, DW'(m));
    bist_en = 1;
  endtask

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  function automatic logic [DW-1:0] lnext(input logic [DW-1:0] v);
    return {v[DW-2:0], v[3] ^ v[2]};
  endfunction

  function automatic logic [DW-1:0] expv(input int m, input int t,
                                         input logic [DW-1:0] lf,
                                         input logic [DW-1:0] mg);
    int b, ph, k, per;
    logic [DW-1:0] v;
    b = m;
    case (m)
      10: b = 0; 11: b = 1; 12: b = 2; 13: b = 3; 14: b = 7; 15: b = 8;
      default: b = m;
    endcase
    ph  = t % 16;
    k   = (t / 16) % SW;
    per = 2 * 15;
    case (b)
      0: v = DW'(ph);
      1: v = DW'((16 - ph) % 16);
      2: v = DW'(((t % per) <= 15) ? (t % per) : per - (t % per));
      3: v = lf;
      4: v = mg;
      5: v = ((t % 32) < 16) ? '0 : mg;
      6: v = (ph == 0) ? mg : '0;
      7: v = ((ph >> k) & 1) ? mg : '0;
      8: v = ((ph >> k) & 1) ? DW'(15 >> k) : '0;
      default: v = DW'(ph & ~3);
    endcase
    return (m >= 10) ? rev(v) : v;
  endfunction

  function automatic string tag(input int m);
    case (m)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7, 8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] lf;
    logic [DW-1:0] mg;
    logic [DW-1:0] first;
    // R11-style reset state folded into R2: code 0, core 0
    bist_en = 1;
    sys_data = 4'h5;
    #20;
    chk("R2 reset code0 output", dac, 4'h0);
    @(negedge clk);
    rst_n = 1;
    bist_en = 0;
    @(negedge clk);
    // R1: exhaustive pass-through
    for (int d = 0; d < 16; d++) begin
      sys_data = DW'(d);
      #1 chk("R1 bypass", dac, DW'(d));
      #1;
    end
    @(negedge clk);
    // R6: reset magnitude is zero
    start(4);
    #1 chk("R2 reset magnitude", dac, 4'h0);
    @(negedge clk);
    bist_en = 0;
    mg = 4'hB;
    wr(1, mg);
    // all sixteen codes
    for (int m = 0; m < 16; m++) begin
      start(m);
      lf = 4'h1;
      first = '0;
      for (int t = 0; t < 70; t++) begin
        #1;
        chk(tag(m), dac, expv(m, t, lf, mg));
        if (m == 3 && t == 0) first = dac;
        if (m == 3 && t == 15) chk("R5 period", dac, first);
        if (m == 3) checks++;
        if (m == 3 && dac == '0) begin
          errors++;
          $display("FAIL R5 zero actual=%0h expected=nonzero", dac);
        end
        lf = lnext(lf);
        @(negedge clk);
      end
      bist_en = 0;
      sys_data = 4'h9;
      #1 chk("R1 parked after run", dac, 4'h9);
      @(negedge clk);
    end
    // R6: magnitude change mid-impulse keeps the phase
    start(6);
    for (int t = 0; t < 10; t++) begin
      #1 chk("R6 before write", dac, expv(6, t, '0, mg));
      @(negedge clk);
    end
    #1;
    wr(1, 4'h6);
    for (int t = 11; t < 40; t++) begin
      #1 chk("R6 after write", dac, expv(6, t, '0, 4'h6));
      @(negedge clk);
    end
    // R2: code write during a run restarts the waveform
    start(0);
    for (int t = 0; t < 6; t++) begin
      #1 chk("R3 pre-restart", dac, DW'(t));
      @(negedge clk);
    end
    wr(0, 4'd2);
    for (int t = 0; t < 35; t++) begin
      #1 chk("R2 restart into triangle", dac, expv(2, t, '0, mg));
      @(negedge clk);
    end
    // R1: enable low parks state; re-enable starts at t=0
    bist_en = 0;
    repeat (5) @(negedge clk);
    bist_en = 1;
    #1 chk("R1 restart from park", dac, 4'h0);
    @(negedge clk);
    #1 chk("R4 first step", dac, 4'h1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule